// File: doc/BRIEF.md
# Shift-then-ALU Datapath Stage with Condition Flags

This block is one stage of a 32-bit integer datapath. The second operand first goes through a barrel shifter that can shift left, shift right logically, shift right arithmetically or rotate right. The shifted value then goes to an ALU that can add, subtract, compare, do a bitwise AND, OR or XOR, or move. Both steps happen in the same cycle. The stage produces a result word and the four condition flags: negative, zero, carry and overflow. It also produces two strobes, one that tells the register file whether to write the result and one that tells the status register whether to take the flags.

Operations enter and leave over valid/ready handshakes, and a single output register sits between the two sides. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its outputs appear with `out_valid` on the next cycle. They stay frozen until a cycle in which `out_ready` is high. `in_ready` is high when the output register is empty or is being drained in that same cycle, so back-pressure costs no bubble.

The carry flag depends on the kind of operation. Adds report the carry out of bit 31. Subtracts report the inverse of a borrow. Logical operations report the last bit the shifter pushed out. The overflow flag is only ever written by adds and subtracts.

Top module: `shift_alu`

## Requirements
- R1: An operation accepted at a clock edge (`in_valid` and `in_ready` high) is presented with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, the outputs stay stable and `in_ready` is low. Otherwise `in_ready` is high. After reset `out_valid` is 0.
- R2: `out_n` equals bit 31 of `out_res`.
- R3: `out_z` is 1 exactly when `out_res` is all zeros.
- R4: For ADD (op code 0) and CMN (op code 3), the result is A plus the shifted B. C is the unsigned carry out of bit 31. V is 1 when both inputs have the same sign and the result's sign differs from it.
- R5: For SUB (op code 1) and CMP (op code 2), the result is A minus the shifted B. C is 0 when a borrow occurs and 1 otherwise. V is 1 when the inputs have different signs and the result's sign differs from A's sign.
- R6: For AND (4), OR (5), XOR (6) and MOV (7, result is the shifted B), C is the last bit shifted out when the shift amount is nonzero. A shift amount of 0 passes B through unchanged and C equals `in_c`.
- R7: V equals `in_v` for op codes 4 to 7.
- R8: CMP and CMN drive `out_wr` to 0 and `out_flags_we` to 1. All other op codes drive `out_wr` to 1 and `out_flags_we` equal to `in_setf`.
- R9: LSL (shift type 0) and LSR (shift type 1) by exactly 32 give a zero result, with C equal to bit 0 (LSL) or bit 31 (LSR) of B. Amounts above 32 give zero with C equal to 0.
- R10: ASR (shift type 2) by 32 or more fills the result with bit 31 of B, and C equals bit 31 of B.
- R11: ROR (shift type 3) rotates by the amount modulo 32, and C equals bit 31 of the rotated value. A nonzero multiple of 32 leaves B unchanged and C equals bit 31 of B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | Stage can accept an operation |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand (shifted) |
| in_op | input | 3 | Operation code |
| in_shtype | input | 2 | Shift type |
| in_shamt | input | 8 | Shift amount |
| in_setf | input | 1 | Request flag update |
| in_c | input | 1 | Current carry flag |
| in_v | input | 1 | Current overflow flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 32 | Result word |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_c | output | 1 | Carry flag |
| out_v | output | 1 | Overflow flag |
| out_wr | output | 1 | Register write enable |
| out_flags_we | output | 1 | Flag update enable |

## Verification
Some behaviours are checked by assertions on every cycle. These are the handshake holding the output steady under back-pressure, the negative and zero flags agreeing with the held result, overflow passing through untouched on logical operations, carry passing through on zero-amount logical operations, and compares never asserting the write strobe. The remaining behaviours can only be shown by the bench's scenarios with known operands and expected results. These are the arithmetic values, carry-versus-borrow polarity, signed overflow detection, and the shifter's edge amounts of 32, above 32 and multiples of 32 for rotate.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_CMN = 3'd3,
    OP_AND = 3'd4,
    OP_ORR = 3'd5,
    OP_EOR = 3'd6,
    OP_MOV = 3'd7
  } alu_op_e;
endpackage

// File: rtl/sa_shifter.sv
module sa_shifter
  import shift_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  x,
  input  sh_kind_e      kind,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  y,
  output logic          cout,
  output logic          cvalid
);
  localparam int LW = $clog2(W);

  logic [W:0]        lft;
  logic [W:0]        rgt;
  logic signed [W:0] ars;
  logic [AW-1:0]     amt_clamp;
  logic [LW-1:0]     rot;
  logic [LW:0]       back;

  always_comb begin
    amt_clamp = (amt > AW'(W)) ? AW'(W) : amt;
    rot       = amt[LW-1:0];
    back      = (LW+1)'(W) - {1'b0, rot};
    lft       = {1'b0, x} << amt;
    rgt       = {x, 1'b0} >> amt;
    ars       = $signed({x, 1'b0}) >>> amt_clamp;
    cvalid    = (amt != '0);
    y         = x;
    cout      = 1'b0;
    case (kind)
      SH_LSL: begin y = lft[W-1:0]; cout = lft[W]; end
      SH_LSR: begin y = rgt[W:1];   cout = rgt[0]; end
      SH_ASR: begin y = ars[W:1];   cout = ars[0]; end
      default: begin
        if (rot == '0) y = x;
        else           y = (x >> rot) | (x << back);
        cout = y[W-1];
      end
    endcase
  end
endmodule

// File: rtl/sa_alu.sv
module sa_alu
  import shift_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  input  logic         sh_c,
  input  logic         sh_cvalid,
  input  logic         c_in,
  input  logic         v_in,
  output logic [W-1:0] res,
  output logic         n,
  output logic         z,
  output logic         c,
  output logic         v,
  output logic         is_cmp
);
  logic         is_sub;
  logic         is_arith;
  logic [W-1:0] b_eff;
  logic [W:0]   sum;

  always_comb begin
    is_sub   = (op == OP_SUB) || (op == OP_CMP);
    is_arith = is_sub || (op == OP_ADD) || (op == OP_CMN);
    is_cmp   = (op == OP_CMP) || (op == OP_CMN);
    b_eff    = is_sub ? ~b : b;
    sum      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
    case (op)
      OP_AND:  res = a & b;
      OP_ORR:  res = a | b;
      OP_EOR:  res = a ^ b;
      OP_MOV:  res = b;
      default: res = sum[W-1:0];
    endcase
    n = res[W-1];
    z = (res == '0);
    if (is_arith) begin
      c = sum[W];
      v = (a[W-1] == b_eff[W-1]) && (res[W-1] != a[W-1]);
    end else begin
      c = sh_cvalid ? sh_c : c_in;
      v = v_in;
    end
  end
endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import shift_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  input  logic [2:0]    in_op,
  input  logic [1:0]    in_shtype,
  input  logic [AW-1:0] in_shamt,
  input  logic          in_setf,
  input  logic          in_c,
  input  logic          in_v,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_res,
  output logic          out_n,
  output logic          out_z,
  output logic          out_c,
  output logic          out_v,
  output logic          out_wr,
  output logic          out_flags_we
);
  logic [W-1:0] sh_y;
  logic         sh_c, sh_cv;
  logic [W-1:0] alu_res;
  logic         f_n, f_z, f_c, f_v, cmp;
  logic         accept;

  sa_shifter #(.W(W), .AW(AW)) u_shift (
    .x(in_b), .kind(sh_kind_e'(in_shtype)), .amt(in_shamt),
    .y(sh_y), .cout(sh_c), .cvalid(sh_cv)
  );

  sa_alu #(.W(W)) u_alu (
    .a(in_a), .b(sh_y), .op(alu_op_e'(in_op)), .sh_c(sh_c), .sh_cvalid(sh_cv),
    .c_in(in_c), .v_in(in_v), .res(alu_res), .n(f_n), .z(f_z), .c(f_c),
    .v(f_v), .is_cmp(cmp)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_res      <= '0;
      out_n        <= 1'b0;
      out_z        <= 1'b0;
      out_c        <= 1'b0;
      out_v        <= 1'b0;
      out_wr       <= 1'b0;
      out_flags_we <= 1'b0;
    end else if (accept) begin
      out_valid    <= 1'b1;
      out_res      <= alu_res;
      out_n        <= f_n;
      out_z        <= f_z;
      out_c        <= f_c;
      out_v        <= f_v;
      out_wr       <= !cmp;
      out_flags_we <= cmp || in_setf;
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res) && $stable(out_c)); // R1
  AST_N_IS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_n == out_res[W-1]); // R2
  AST_Z_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_z == (out_res == '0)); // R3
  AST_ZERO_SHIFT_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op[2] && in_shamt == '0 |=> out_c == $past(in_c)); // R6
  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op[2] |=> out_v == $past(in_v)); // R7
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 3'd2 || in_op == 3'd3) |=> !out_wr && out_flags_we); // R8
endmodule

// File: tb/test_shift_alu.sv
module test_shift_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [31:0] in_a = '0, in_b = '0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_shtype = '0;
  logic [7:0]  in_shamt = '0;
  logic        in_setf = 1'b0, in_c = 1'b0, in_v = 1'b0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_n, out_z, out_c, out_v, out_wr, out_flags_we;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  shift_alu i_shift_alu (.*);

  localparam int NV = 21;
  // {op, shtype, shamt, setf, c, v, a, b, res, nzcv, wr, flags_we}
  localparam logic [117:0] VEC [NV] = '{
    {3'd0,2'd0,8'd0, 1'b1,1'b0,1'b0,32'h00000001,32'h00000002,32'h00000003,4'b0000,1'b1,1'b1}, // R4
    {3'd0,2'd0,8'd0, 1'b1,1'b0,1'b0,32'hFFFFFFFF,32'h00000001,32'h00000000,4'b0110,1'b1,1'b1}, // R4 R3
    {3'd0,2'd0,8'd0, 1'b1,1'b0,1'b0,32'h7FFFFFFF,32'h00000001,32'h80000000,4'b1001,1'b1,1'b1}, // R4 R2
    {3'd1,2'd0,8'd0, 1'b1,1'b0,1'b0,32'h00000005,32'h00000003,32'h00000002,4'b0010,1'b1,1'b1}, // R5
    {3'd1,2'd0,8'd0, 1'b1,1'b1,1'b0,32'h00000003,32'h00000005,32'hFFFFFFFE,4'b1000,1'b1,1'b1}, // R5
    {3'd1,2'd0,8'd0, 1'b1,1'b0,1'b0,32'h80000000,32'h00000001,32'h7FFFFFFF,4'b0011,1'b1,1'b1}, // R5
    {3'd2,2'd0,8'd0, 1'b0,1'b0,1'b0,32'h00000007,32'h00000007,32'h00000000,4'b0110,1'b0,1'b1}, // R8 R5
    {3'd3,2'd0,8'd0, 1'b0,1'b0,1'b0,32'h00000001,32'hFFFFFFFF,32'h00000000,4'b0110,1'b0,1'b1}, // R8 R4
    {3'd4,2'd0,8'd0, 1'b1,1'b1,1'b1,32'hF0F0F0F0,32'hFF00FF00,32'hF000F000,4'b1011,1'b1,1'b1}, // R6 R7
    {3'd5,2'd0,8'd31,1'b1,1'b0,1'b0,32'h00000000,32'h00000003,32'h80000000,4'b1010,1'b1,1'b1}, // R6
    {3'd6,2'd1,8'd1, 1'b1,1'b0,1'b0,32'hFFFFFFFF,32'h80000001,32'hBFFFFFFF,4'b1010,1'b1,1'b1}, // R6
    {3'd7,2'd2,8'd4, 1'b1,1'b1,1'b1,32'h00000000,32'h80000000,32'hF8000000,4'b1001,1'b1,1'b1}, // R6 R7
    {3'd7,2'd2,8'd40,1'b1,1'b0,1'b0,32'h00000000,32'h80000000,32'hFFFFFFFF,4'b1010,1'b1,1'b1}, // R10
    {3'd7,2'd2,8'd32,1'b1,1'b1,1'b0,32'h00000000,32'h7FFFFFFF,32'h00000000,4'b0100,1'b1,1'b1}, // R10
    {3'd7,2'd3,8'd1, 1'b1,1'b0,1'b0,32'h00000000,32'h00000001,32'h80000000,4'b1010,1'b1,1'b1}, // R11
    {3'd7,2'd3,8'd32,1'b1,1'b0,1'b0,32'h00000000,32'h80000001,32'h80000001,4'b1010,1'b1,1'b1}, // R11
    {3'd7,2'd0,8'd32,1'b1,1'b0,1'b0,32'h00000000,32'h00000001,32'h00000000,4'b0110,1'b1,1'b1}, // R9
    {3'd7,2'd1,8'd32,1'b1,1'b0,1'b0,32'h00000000,32'h80000000,32'h00000000,4'b0110,1'b1,1'b1}, // R9
    {3'd7,2'd0,8'd33,1'b1,1'b1,1'b0,32'h00000000,32'hFFFFFFFF,32'h00000000,4'b0100,1'b1,1'b1}, // R9
    {3'd7,2'd3,8'd0, 1'b0,1'b1,1'b0,32'h00000000,32'h12345678,32'h12345678,4'b0010,1'b1,1'b0}, // R6 R8
    {3'd0,2'd0,8'd4, 1'b1,1'b1,1'b0,32'h00000001,32'h00000001,32'h00000011,4'b0000,1'b1,1'b1}  // R4
  };

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [117:0] v);
    @(negedge clk);
    {in_op, in_shtype, in_shamt, in_setf, in_c, in_v, in_a, in_b} = v[117:38];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {36'd0, out_valid, in_ready}, {36'd0, 1'b0, 1'b1});
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("vec%0d R2-R11", i),
            {out_res, out_n, out_z, out_c, out_v, out_wr, out_flags_we},
            {VEC[i][37:0]});
      check($sformatf("vec%0d R1 valid", i), {37'd0, out_valid}, 38'd1);
    end
    // R1: back-pressure holds result, refuses new input
    @(negedge clk);
    out_ready = 1'b0;
    drive(VEC[0]);
    check("R1 stalled valid/ready", {36'd0, out_valid, in_ready}, {36'd0, 1'b1, 1'b0});
    {in_op, in_shtype, in_shamt, in_setf, in_c, in_v, in_a, in_b} = VEC[2][117:38];
    in_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 held result", {6'd0, out_res}, {6'd0, 32'h00000003});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 next after release", {6'd0, out_res}, {6'd0, 32'h80000000});
    @(negedge clk);
    check("R1 drained", {37'd0, out_valid}, 38'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule